// File: doc/BRIEF.md
# Priority-Mapped System Interrupt Controller

This block gathers 64 level-sensitive peripheral interrupt lines, organised as two banks of 32, and distributes them over seven core priority levels numbered 0 to 6 (level 0 maps to the core's seventh event slot and level 6 to its thirteenth). Every line carries a 4-bit level field, a mask bit and a wakeup-enable bit, all held in word registers behind a simple single-cycle read/write port.

For each level the block drives a registered request line and the index of the lowest-numbered line that is both raw-active and masked-in and is routed to that level. A handler can therefore find its source without scanning status. When the core takes a level that has no such line at that moment, the event is counted as spurious in a saturating counter. A separate registered wakeup output is high whenever any raw-active line has its wakeup enable set.

Top module: `sic_top`

## Requirements
- R1: After reset all mask bits and wakeup bits are 0, the spurious counter is 0, all outputs are 0, and the level field of line n is min(n/4, 6). With these defaults, word 0 reads 0x11110000, word 1 reads 0x33332222 and word 3 reads 0x66666666.
- R2: The register map uses word addresses on `reg_addr_i`.
  - Words 0 to 7 are level-field registers. Word a holds lines 8a to 8a+7, and line n sits at bits [4(n%8)+3 : 4(n%8)].
  - Words 8 and 9 are the mask registers of banks 0 and 1.
  - Words 10 and 11 are the wakeup registers of banks 0 and 1.
  - Words 12 and 13 read the raw status of banks 0 and 1. They are read-only, and a write to them changes nothing.
  - Word 14 reads the spurious count in its low bits.
  - Reads are combinational. Writes take effect at the clock edge where `reg_sel_i` and `reg_we_i` are both high.
- R3: Line n belongs to bank n/32 at bit n%32. A line is pending when its raw status bit and its mask bit are both 1.
- R4: A level field value v from 0 to 6 routes the line to level v. Values 7 to 15 route the line to no level.
- R5: `lvl_req_o[v]` is 1 when at least one pending line is routed to level v. `lvl_src_o[6v+5:6v]` is then the lowest index among those lines, and it is 0 when there is none.
- R6: Level requests, source indices and the wakeup output are registered. They reflect the inputs and register contents of the previous clock edge, with one cycle of latency.
- R7: `wake_o` is 1 when any line has both its raw status bit and its wakeup bit set, regardless of its mask bit and its level field.
- R8: A cycle with `take_i` high and `take_lvl_i` equal to v (v < 7) increments the spurious counter by one if no pending line is routed to level v in that cycle. The counter saturates at 2^CNT_W-1 (15). A take on a level that has a pending line leaves the counter unchanged.
- R9: Raw status is not latched. When a line's raw bit falls, its request disappears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_sel_i | input | 1 | Register port select |
| reg_we_i | input | 1 | Write enable (with select) |
| reg_addr_i | input | 4 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| raw_stat_i | input | 64 | Raw level-sensitive interrupt lines |
| take_i | input | 1 | Core takes a level this cycle |
| take_lvl_i | input | 3 | Level being taken |
| lvl_req_o | output | 7 | Per-level request |
| lvl_src_o | output | 42 | Per-level winning line index, 6 bits per level |
| wake_o | output | 1 | Wakeup request |

## Verification
On every cycle the assertions check four things: a raised level request names a line that was pending on that level one cycle earlier; no lower-indexed line on that level was pending; the wakeup output follows raw status ANDed with the wakeup enables with one cycle of delay; and the spurious counter only steps by one and sticks at its maximum. They also check that writes to the read-only status words leave the registers unchanged. Only the bench scenarios can show the rest:
- the exact reset field layout and the register-map decoding;
- that an out-of-range field silences a line;
- that a take on a level with a pending line is not counted;
- the precise source index chosen for the chosen masks and level fields.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int NLINES     = 64;
    localparam int BANK_W     = 32;
    localparam int NBANK      = NLINES / BANK_W;
    localparam int FLD_W      = 4;
    localparam int DATA_W     = 32;
    localparam int FLD_PER_WD = DATA_W / FLD_W;
    localparam int NASSIGN    = NLINES / FLD_PER_WD;
    localparam int NLVL       = 7;
    localparam int LVL_W      = 3;
    localparam int IDX_W      = $clog2(NLINES);
    localparam int CNT_W      = 4;
    localparam int ADDR_W     = 4;
    localparam int ADR_ASSIGN = 0;
    localparam int ADR_MASK   = ADR_ASSIGN + NASSIGN;
    localparam int ADR_WAKE   = ADR_MASK + NBANK;
    localparam int ADR_STAT   = ADR_WAKE + NBANK;
    localparam int ADR_SPUR   = ADR_STAT + NBANK;

    typedef struct packed {
        logic [NLINES*FLD_W-1:0] fld;
        logic [NLINES-1:0]       mask;
        logic [NLINES-1:0]       wake;
    } regs_t;

    typedef struct packed {
        logic [NLVL-1:0]            req;
        logic [NLVL-1:0][IDX_W-1:0] src;
        logic                       wake;
    } outs_t;

    function automatic logic [NLINES*FLD_W-1:0] dflt_fields();
        logic [NLINES*FLD_W-1:0] f;
        f = '0;
        for (int n = 0; n < NLINES; n++) begin
            f[n*FLD_W +: FLD_W] = (n / 4 > NLVL - 1) ? FLD_W'(NLVL - 1) : FLD_W'(n / 4);
        end
        return f;
    endfunction

    localparam regs_t REGS_RST = '{fld: dflt_fields(), mask: '0, wake: '0};
endpackage

// File: rtl/sic_regfile.sv
module sic_regfile
    import sic_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    sel_i,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [NLINES-1:0]       raw_i,
    input  logic [CNT_W-1:0]        spur_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [NLINES*FLD_W-1:0] fld_o,
    output logic [NLINES-1:0]       mask_o,
    output logic [NLINES-1:0]       wake_o
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sel_i && we_i) begin
            for (int r = 0; r < NASSIGN; r++) begin
                if (int'(addr_i) == ADR_ASSIGN + r) r_d.fld[r*DATA_W +: DATA_W] = wdata_i;
            end
            for (int b = 0; b < NBANK; b++) begin
                if (int'(addr_i) == ADR_MASK + b) r_d.mask[b*BANK_W +: BANK_W] = wdata_i[BANK_W-1:0];
                if (int'(addr_i) == ADR_WAKE + b) r_d.wake[b*BANK_W +: BANK_W] = wdata_i[BANK_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < NASSIGN; r++) begin
            if (int'(addr_i) == ADR_ASSIGN + r) rdata_o = r_q.fld[r*DATA_W +: DATA_W];
        end
        for (int b = 0; b < NBANK; b++) begin
            if (int'(addr_i) == ADR_MASK + b) rdata_o[BANK_W-1:0] = r_q.mask[b*BANK_W +: BANK_W];
            if (int'(addr_i) == ADR_WAKE + b) rdata_o[BANK_W-1:0] = r_q.wake[b*BANK_W +: BANK_W];
            if (int'(addr_i) == ADR_STAT + b) rdata_o[BANK_W-1:0] = raw_i[b*BANK_W +: BANK_W];
        end
        if (int'(addr_i) == ADR_SPUR) rdata_o[CNT_W-1:0] = spur_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= REGS_RST;
        else         r_q <= r_d;
    end

    assign fld_o  = r_q.fld;
    assign mask_o = r_q.mask;
    assign wake_o = r_q.wake;

    // R2: status and counter words are read-only
    p_ro_words_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && we_i && int'(addr_i) >= ADR_STAT) |=> (r_q == $past(r_q)));
endmodule

// File: rtl/sic_level_pick.sv
module sic_level_pick
    import sic_pkg::*;
#(
    parameter int LVL = 0
) (
    input  logic [NLINES-1:0]       pend_i,
    input  logic [NLINES*FLD_W-1:0] fld_i,
    output logic [NLINES-1:0]       cand_o,
    output logic                    hit_o,
    output logic [IDX_W-1:0]        idx_o
);
    always_comb begin
        for (int n = 0; n < NLINES; n++) begin
            cand_o[n] = pend_i[n] && (fld_i[n*FLD_W +: FLD_W] == FLD_W'(LVL));
        end
        hit_o = |cand_o;
        idx_o = '0;
        for (int n = NLINES - 1; n >= 0; n--) begin
            if (cand_o[n]) idx_o = IDX_W'(n);
        end
    end
endmodule

// File: rtl/sic_spur_cnt.sv
module sic_spur_cnt
    import sic_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             take_i,
    input  logic [LVL_W-1:0] take_lvl_i,
    input  logic [NLVL-1:0]  hit_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int HX = 1 << LVL_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [HX-1:0]    hit_ext;
    logic             lvl_ok;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit_ext = HX'(hit_i);
        lvl_ok  = int'(take_lvl_i) < NLVL;
        cnt_d   = cnt_q;
        if (take_i && lvl_ok && !hit_ext[take_lvl_i] && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R8: counter only moves up by one
    p_spur_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));
    // R8: saturation holds
    p_spur_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/sic_top.sv
module sic_top
    import sic_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    reg_sel_i,
    input  logic                    reg_we_i,
    input  logic [ADDR_W-1:0]       reg_addr_i,
    input  logic [DATA_W-1:0]       reg_wdata_i,
    output logic [DATA_W-1:0]       reg_rdata_o,
    input  logic [NLINES-1:0]       raw_stat_i,
    input  logic                    take_i,
    input  logic [LVL_W-1:0]        take_lvl_i,
    output logic [NLVL-1:0]         lvl_req_o,
    output logic [NLVL*IDX_W-1:0]   lvl_src_o,
    output logic                    wake_o
);
    logic [NLINES*FLD_W-1:0]    fld;
    logic [NLINES-1:0]          mask, wake_en, pend;
    logic [NLVL-1:0][NLINES-1:0] cand;
    logic [NLVL-1:0]            hit;
    logic [NLVL-1:0][IDX_W-1:0] idx;
    logic [CNT_W-1:0]           spur;
    outs_t                      o_d, o_q;

    sic_regfile u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (reg_sel_i),
        .we_i   (reg_we_i),
        .addr_i (reg_addr_i),
        .wdata_i(reg_wdata_i),
        .raw_i  (raw_stat_i),
        .spur_i (spur),
        .rdata_o(reg_rdata_o),
        .fld_o  (fld),
        .mask_o (mask),
        .wake_o (wake_en)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign pend[b*BANK_W +: BANK_W] = raw_stat_i[b*BANK_W +: BANK_W] & mask[b*BANK_W +: BANK_W];
    end

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        sic_level_pick #(.LVL(l)) u_pick (
            .pend_i(pend),
            .fld_i (fld),
            .cand_o(cand[l]),
            .hit_o (hit[l]),
            .idx_o (idx[l])
        );

        // R5: a reported source was pending on this level
        p_src_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            o_q.req[l] |-> ((($past(cand[l]) >> o_q.src[l]) & NLINES'(1)) != '0));
        // R5: no lower-indexed candidate was skipped
        p_src_lowest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            o_q.req[l] |-> (($past(cand[l]) & ((NLINES'(1) << o_q.src[l]) - NLINES'(1))) == '0));
    end

    sic_spur_cnt u_spur (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .take_i    (take_i),
        .take_lvl_i(take_lvl_i),
        .hit_i     (hit),
        .cnt_o     (spur)
    );

    always_comb begin
        o_d      = o_q;
        o_d.req  = hit;
        o_d.src  = idx;
        o_d.wake = |(raw_stat_i & wake_en);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) o_q <= '0;
        else         o_q <= o_d;
    end

    assign lvl_req_o = o_q.req;
    assign lvl_src_o = o_q.src;
    assign wake_o    = o_q.wake;

    // R7: wake follows enabled raw lines one cycle later
    p_wake_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(raw_stat_i & wake_en)) |=> wake_o);
    p_wake_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> $past(|(raw_stat_i & wake_en)));
endmodule

// File: tb/sim_sic_top.sv
`timescale 1ns/1ps
module sim_sic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] raw = '0;
    logic        take = 1'b0;
    logic [2:0]  take_lvl = '0;
    logic [6:0]  lvl_req;
    logic [41:0] lvl_src;
    logic        wake;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sic_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .raw_stat_i(raw), .take_i(take), .take_lvl_i(take_lvl),
        .lvl_req_o(lvl_req), .lvl_src_o(lvl_src), .wake_o(wake)
    );

    typedef struct packed {
        logic [63:0] raw;
        logic [63:0] mask;
        logic [2:0]  lvl;
        logic        req;
        logic [5:0]  src;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{64'h20, 64'hFFFF_FFFF_FFFF_FFFF, 3'd1, 1'b1, 6'd5},
        '{64'h50, 64'hFFFF_FFFF_FFFF_FFFF, 3'd1, 1'b1, 6'd4},
        '{64'h50, 64'hFFFF_FFFF_FFFF_FFEF, 3'd1, 1'b1, 6'd6},
        '{64'h0000_0102_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 3'd6, 1'b1, 6'd33},
        '{64'h0000_0100_4000_0000, 64'hFFFF_FFFF_BFFF_FFFF, 3'd6, 1'b1, 6'd40},
        '{64'h4, 64'h0, 3'd0, 1'b0, 6'd0},
        '{64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 3'd6, 1'b1, 6'd63},
        '{64'h600, 64'hFFFF_FFFF_FFFF_FFFF, 3'd2, 1'b1, 6'd9}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    function automatic logic [5:0] src_of(input int l);
        return lvl_src[l*6 +: 6];
    endfunction

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, d);  chk("R1 field word0", d, 32'h1111_0000);
        rd(4'd1, d);  chk("R1 field word1", d, 32'h3333_2222);
        rd(4'd3, d);  chk("R1 field word3", d, 32'h6666_6666);
        rd(4'd8, d);  chk("R1 mask0", d, 0);
        rd(4'd11, d); chk("R1 wake1", d, 0);
        rd(4'd14, d); chk("R1 spur", d, 0);
        chk("R1 outputs", {lvl_req, lvl_src, wake}, 0);

        // R3 R5 vector table
        for (int i = 0; i < NV; i++) begin
            wr(4'd8, TBL[i].mask[31:0]);
            wr(4'd9, TBL[i].mask[63:32]);
            raw = TBL[i].raw;
            @(negedge clk);
            chk($sformatf("R5 vec%0d req", i), 64'(lvl_req[TBL[i].lvl]), 64'(TBL[i].req));
            chk($sformatf("R3 vec%0d src", i), 64'(src_of(int'(TBL[i].lvl))), 64'(TBL[i].src));
        end

        // R6 latency and R9 no latching
        wr(4'd8, 32'hFFFF_FFFF); wr(4'd9, 32'hFFFF_FFFF);
        raw = '0;
        @(negedge clk);
        raw = 64'h20;
        #1;
        chk("R6 before edge", 64'(lvl_req), 0);
        @(negedge clk);
        chk("R6 after edge", 64'(lvl_req), 64'h2);
        raw = '0;
        @(negedge clk);
        chk("R9 request drops", 64'(lvl_req), 0);

        // R4 reassignment and invalid level
        wr(4'd0, 32'h1111_0030);
        raw = 64'h2002;
        @(negedge clk);
        chk("R4 line1 on level3 req", 64'(lvl_req), 64'h8);
        chk("R4 line1 wins level3", 64'(src_of(3)), 1);
        wr(4'd0, 32'h1111_0070);
        raw = 64'h2;
        @(negedge clk);
        chk("R4 field 7 silent", 64'(lvl_req), 0);
        wr(4'd0, 32'h1111_0000);
        raw = '0;

        // R2 status read and read-only
        raw = 64'hA5A5_0000_1234_5678;
        rd(4'd12, d); chk("R2 status bank0", d, 32'h1234_5678);
        rd(4'd13, d); chk("R2 status bank1", d, 32'hA5A5_0000);
        wr(4'd12, 32'h0);
        rd(4'd8, d);  chk("R2 status write ignored", d, 32'hFFFF_FFFF);
        raw = '0;

        // R7 wakeup independent of mask
        wr(4'd8, 32'h0); wr(4'd9, 32'h0);
        wr(4'd11, 32'h100);
        raw = 64'h0000_0100_0000_0000;
        @(negedge clk);
        chk("R7 wake on line40", 64'(wake), 1);
        chk("R7 masked no request", 64'(lvl_req), 0);
        raw = 64'h0000_0200_0000_0000;
        @(negedge clk);
        chk("R7 line41 no wake", 64'(wake), 0);
        wr(4'd11, 32'h0);
        raw = '0;

        // R8 spurious counting
        wr(4'd8, 32'hFFFF_FFFF);
        raw = 64'h100;
        take_lvl = 3'd2; take = 1'b1;
        @(negedge clk);
        take = 1'b0;
        rd(4'd14, d); chk("R8 real take not counted", d, 0);
        raw = '0;
        take = 1'b1;
        @(negedge clk);
        take = 1'b0;
        rd(4'd14, d); chk("R8 one spurious", d, 1);
        take = 1'b1;
        repeat (20) @(negedge clk);
        take = 1'b0;
        rd(4'd14, d); chk("R8 saturates", d, 15);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule